// File: doc/BRIEF.md
# Keyspace Search Candidate Controller

This block runs an exhaustive key search over a programmable slice of a key space. Once started, it presents one candidate key per clock to an external encryption pipeline. That pipeline has a fixed latency and sits outside this block. Each ciphertext that comes back is compared against a small table of target values in a single cycle. When a ciphertext matches, the block records the candidate that produced it.

Candidates come from one of two sources. The first is a plain binary counter over the low bits of the key. The second is a mixed-radix counter of per-character indices, where each index is mapped to a byte through a selectable character set. The set can optionally be folded to upper case. The start position comes from configuration and the current position is always visible. A host can therefore give several engines disjoint ranges, and it can restart a stopped search where it left off. Matches are queued in a small result FIFO, and sticky flags record which targets were hit.

Top module: `keysearch_ctrl`

## Requirements
- R1: After reset, no candidate is issued, and busy, done, hit, the hit mask, overflow and the FIFO valid output are all 0.
- R2: A start pulse accepted at a clock edge makes cand_valid_o high in the next cycle. From then on, exactly one candidate is issued per cycle with no gap until the run ends.
- R3: Mode code 0 is the binary mode. The low cfg_span_i bits count upward from the start value's low bits until they are all ones, and the upper bits stay at their start value. With a span of 0, exactly one candidate is issued.
- R4: Mode code 1 is the printable mode. Each key byte is the idx-th character of the ascending range 0x20..0x7E, so the radix is 95. Byte 0 is the least significant digit, only the low cfg_span_i characters are iterated, and the start and position values hold character indices.
- R5: Mode code 2 is the alphanumeric mode. The characters run in the order '0'-'9', then 'A'-'Z', then 'a'-'z', so the radix is 62.
- R6: With cfg_upper_i set, 'a'-'z' are removed from the selected set and the order of the rest is kept. The printable radix becomes 69 and the alphanumeric radix becomes 36.
- R7: Each valid result is compared against every enabled target at once. On a match, the FIFO receives {lowest matching target index, the candidate issued LAT cycles earlier}. The bit of every matching target is set in the sticky hit mask.
- R8: With cfg_stop_i set, no candidate is issued after the cycle in which a match is seen. Candidates already in flight are still compared. The position then names the next unissued candidate.
- R9: When the range is used up or the search is stopped, done_o rises only after the last in-flight result has been compared. While done_o is high, no candidate is issued and the position holds. When the range is used up, the position holds the last candidate.
- R10: Loading a stopped run's position as the new start continues the sequence with no gap and no repeat.
- R11: A match that arrives while the FIFO is full is dropped and sets the sticky overflow flag. An accepted start clears the hit mask and overflow, but it does not clear the FIFO contents.
- R12: A start pulse is ignored while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; loads the start position |
| cfg_start_i | input | KEY_W | Start position (key value or character indices) |
| cfg_span_i | input | SPAN_W | Number of low bits (binary) or characters iterated |
| cfg_mode_i | input | 2 | 0 binary, 1 printable, 2 alphanumeric |
| cfg_upper_i | input | 1 | Fold lower-case letters out of the set |
| cfg_stop_i | input | 1 | Stop issuing at the first match |
| cfg_targets_i | input | N_TGT*CT_W | Target table, target t at bits t*CT_W |
| cfg_tgt_en_i | input | N_TGT | Per-target enable |
| cand_valid_o | output | 1 | Candidate valid toward the pipeline |
| cand_key_o | output | KEY_W | Candidate key |
| res_valid_i | input | 1 | Result valid from the pipeline |
| res_data_i | input | CT_W | Result ciphertext |
| pos_o | output | KEY_W | Current search position |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished and drained |
| hit_o | output | 1 | Any target matched since start |
| hit_mask_o | output | N_TGT | Sticky per-target match flags |
| overflow_o | output | 1 | A match was dropped because the FIFO was full |
| fifo_valid_o | output | 1 | Result FIFO not empty |
| fifo_tgt_o | output | IDX_W | Target index at the FIFO head |
| fifo_key_o | output | KEY_W | Matching candidate at the FIFO head |
| fifo_pop_i | input | 1 | Remove the FIFO head |

## Verification
Several rules are checked by assertions on every cycle:
- In character modes, every iterated index stays below the radix of its set.
- No lower-case byte is issued while folding is on.
- Results arrive exactly in step with the candidate delay line.
- The hit mask is sticky.
- The FIFO count stays within its depth, and a drop always raises overflow.
- Nothing is issued after a stop or while done is high.

Other behaviour can only be shown by the bench's scenarios:
- the exact candidate order in each mode, including the wrap across the folded letter gap;
- which candidate is paired with which match;
- the position left by a stop and a correct resume from it;
- the FIFO order after an overflow.

// File: rtl/ks_pkg.sv
package ks_pkg;

    typedef enum logic [1:0] {
        KS_MODE_RAW   = 2'd0,
        KS_MODE_PRINT = 2'd1,
        KS_MODE_ALNUM = 2'd2
    } ks_mode_e;

    function automatic logic ks_is_char_mode(ks_mode_e m);
        return (m == KS_MODE_PRINT) || (m == KS_MODE_ALNUM);
    endfunction

    function automatic logic [7:0] ks_radix(ks_mode_e m, logic up);
        case (m)
            KS_MODE_PRINT: return up ? 8'd69 : 8'd95;
            KS_MODE_ALNUM: return up ? 8'd36 : 8'd62;
            default:       return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] ks_idx2char(ks_mode_e m, logic up, logic [7:0] idx);
        case (m)
            KS_MODE_PRINT: begin
                if (up && idx >= 8'd65) return 8'h7B + (idx - 8'd65);
                return 8'h20 + idx;
            end
            KS_MODE_ALNUM: begin
                if (idx < 8'd10) return 8'h30 + idx;
                if (idx < 8'd36) return 8'h41 + (idx - 8'd10);
                return 8'h61 + (idx - 8'd36);
            end
            default: return idx;
        endcase
    endfunction

endpackage

// File: rtl/ks_candgen.sv
module ks_candgen
    import ks_pkg::*;
#(
    parameter int NCHAR = 4,
    localparam int KEY_W = 8 * NCHAR,
    localparam int SPAN_W = $clog2(KEY_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              halt_i,
    input  logic [KEY_W-1:0]  cfg_start_i,
    input  logic [SPAN_W-1:0] cfg_span_i,
    input  logic [1:0]        cfg_mode_i,
    input  logic              cfg_upper_i,
    output logic              cand_valid_o,
    output logic [KEY_W-1:0]  cand_key_o,
    output logic [KEY_W-1:0]  pos_o
);

    typedef struct packed {
        logic             run;
        logic [KEY_W-1:0] pos;
    } cg_state_t;

    cg_state_t q, d;

    ks_mode_e         mode;
    logic             charmode;
    logic [7:0]       radix;
    logic [KEY_W-1:0] char_key;
    logic [KEY_W-1:0] char_next;
    logic             char_last;
    logic [KEY_W-1:0] raw_mask;
    logic [KEY_W-1:0] raw_next;
    logic             raw_last;

    assign mode     = ks_mode_e'(cfg_mode_i);
    assign charmode = ks_is_char_mode(mode);
    assign radix    = ks_radix(mode, cfg_upper_i);

    // Byte-wise character mapping of the index state
    for (genvar gi = 0; gi < NCHAR; gi++) begin : g_map
        assign char_key[8*gi +: 8] = ks_idx2char(mode, cfg_upper_i, q.pos[8*gi +: 8]);
    end

    always_comb begin
        logic       carry;
        logic [7:0] dig;
        logic       dmax;
        carry     = 1'b1;
        char_next = q.pos;
        char_last = 1'b1;
        for (int i = 0; i < NCHAR; i++) begin
            dig  = q.pos[8*i +: 8];
            dmax = (dig == radix - 8'd1);
            if (32'(cfg_span_i) > i) begin
                char_last = char_last & dmax;
                if (carry) char_next[8*i +: 8] = dmax ? 8'd0 : dig + 8'd1;
                carry = carry & dmax;
            end
        end
    end

    always_comb begin
        for (int b = 0; b < KEY_W; b++) raw_mask[b] = (32'(cfg_span_i) > b);
        raw_next = (q.pos & ~raw_mask) | ((q.pos + 1'b1) & raw_mask);
        raw_last = ((q.pos & raw_mask) == raw_mask);
    end

    always_comb begin
        logic             last;
        logic [KEY_W-1:0] nxt;
        d    = q;
        last = charmode ? char_last : raw_last;
        nxt  = charmode ? char_next : raw_next;
        if (load_i) begin
            d.run = 1'b1;
            d.pos = cfg_start_i;
        end else if (q.run) begin
            if (last) begin
                d.run = 1'b0;
            end else begin
                d.pos = nxt;
                if (halt_i) d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cand_valid_o = q.run;
    assign cand_key_o   = charmode ? char_key : q.pos;
    assign pos_o        = q.pos;

    // R4 R5 R6: every iterated index stays inside its character set
    for (genvar gi = 0; gi < NCHAR; gi++) begin : g_chk
        a_r4_index_in_set: assert property (@(posedge clk) disable iff (!rst_n)
            (q.run && charmode) |-> (q.pos[8*gi +: 8] < radix));
        a_r6_no_lower_case: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_valid_o && charmode && cfg_upper_i) |->
            !(cand_key_o[8*gi +: 8] >= 8'h61 && cand_key_o[8*gi +: 8] <= 8'h7A));
    end

endmodule

// File: rtl/ks_match.sv
module ks_match #(
    parameter int KEY_W = 32,
    parameter int CT_W  = 32,
    parameter int N_TGT = 4,
    parameter int LAT   = 4,
    localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  cand_valid_i,
    input  logic [KEY_W-1:0]      cand_key_i,
    input  logic                  res_valid_i,
    input  logic [CT_W-1:0]       res_data_i,
    input  logic [N_TGT*CT_W-1:0] targets_i,
    input  logic [N_TGT-1:0]      tgt_en_i,
    output logic                  push_o,
    output logic [IDX_W-1:0]      push_idx_o,
    output logic [KEY_W-1:0]      push_key_o,
    output logic                  inflight_o,
    output logic [N_TGT-1:0]      hit_mask_o
);

    typedef struct packed {
        logic [LAT-1:0]            v;
        logic [LAT-1:0][KEY_W-1:0] k;
        logic [N_TGT-1:0]          hit;
    } mt_state_t;

    mt_state_t        q, d;
    logic [N_TGT-1:0] m;

    always_comb begin
        for (int t = 0; t < N_TGT; t++)
            m[t] = res_valid_i && tgt_en_i[t] && (res_data_i == targets_i[t*CT_W +: CT_W]);
    end

    always_comb begin
        push_idx_o = '0;
        for (int t = N_TGT - 1; t >= 0; t--)
            if (m[t]) push_idx_o = IDX_W'(t);
    end

    always_comb begin
        d      = q;
        d.v[0] = cand_valid_i;
        d.k[0] = cand_key_i;
        for (int s = 1; s < LAT; s++) begin
            d.v[s] = q.v[s-1];
            d.k[s] = q.k[s-1];
        end
        d.hit = clear_i ? '0 : (q.hit | m);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign push_o     = |m;
    assign push_key_o = q.k[LAT-1];
    assign inflight_o = |q.v;
    assign hit_mask_o = q.hit;

    // R7: results come back exactly LAT cycles after their candidate
    a_r7_result_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_i == q.v[LAT-1]);
    // R7: hit flags never clear except on an accepted start
    a_r7_hit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((hit_mask_o & $past(hit_mask_o)) == $past(hit_mask_o)));

endmodule

// File: rtl/ks_fifo.sv
module ks_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_ovf_i,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         overflow_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } ff_state_t;

    ff_state_t q, d;
    logic      do_pop, room, do_push;

    always_comb begin
        d       = q;
        do_pop  = pop_i && (q.cnt != '0);
        room    = (q.cnt != CW'(DEPTH)) || do_pop;
        do_push = push_i && room;
        if (do_push) begin
            d.mem[q.wp] = data_i;
            d.wp = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        d.ovf = clear_ovf_i ? 1'b0 : (q.ovf | (push_i && !room));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o    = (q.cnt != '0);
    assign data_o     = q.mem[q.rp];
    assign overflow_o = q.ovf;

    // R11: occupancy never exceeds the depth
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    // R11: a push into a full queue without a pop raises overflow
    a_r11_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clear_ovf_i && (q.cnt == CW'(DEPTH)) && !pop_i) |=> overflow_o);

endmodule

// File: rtl/keysearch_ctrl.sv
module keysearch_ctrl #(
    parameter int NCHAR  = 4,
    parameter int CT_W   = 32,
    parameter int N_TGT  = 4,
    parameter int LAT    = 4,
    parameter int FIFO_D = 4,
    localparam int KEY_W  = 8 * NCHAR,
    localparam int SPAN_W = $clog2(KEY_W + 1),
    localparam int IDX_W  = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [KEY_W-1:0]      cfg_start_i,
    input  logic [SPAN_W-1:0]     cfg_span_i,
    input  logic [1:0]            cfg_mode_i,
    input  logic                  cfg_upper_i,
    input  logic                  cfg_stop_i,
    input  logic [N_TGT*CT_W-1:0] cfg_targets_i,
    input  logic [N_TGT-1:0]      cfg_tgt_en_i,
    output logic                  cand_valid_o,
    output logic [KEY_W-1:0]      cand_key_o,
    input  logic                  res_valid_i,
    input  logic [CT_W-1:0]       res_data_i,
    output logic [KEY_W-1:0]      pos_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  hit_o,
    output logic [N_TGT-1:0]      hit_mask_o,
    output logic                  overflow_o,
    output logic                  fifo_valid_o,
    output logic [IDX_W-1:0]      fifo_tgt_o,
    output logic [KEY_W-1:0]      fifo_key_o,
    input  logic                  fifo_pop_i
);

    typedef struct packed {
        logic active;
        logic done;
    } top_state_t;

    top_state_t       q, d;
    logic             accept, halt, any_match, inflight;
    logic [IDX_W-1:0] m_idx;
    logic [KEY_W-1:0] m_key;

    assign accept = start_i && !q.active;
    assign halt   = cfg_stop_i && any_match && cand_valid_o;

    ks_candgen #(.NCHAR(NCHAR)) u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (accept),
        .halt_i       (halt),
        .cfg_start_i  (cfg_start_i),
        .cfg_span_i   (cfg_span_i),
        .cfg_mode_i   (cfg_mode_i),
        .cfg_upper_i  (cfg_upper_i),
        .cand_valid_o (cand_valid_o),
        .cand_key_o   (cand_key_o),
        .pos_o        (pos_o)
    );

    ks_match #(.KEY_W(KEY_W), .CT_W(CT_W), .N_TGT(N_TGT), .LAT(LAT)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (accept),
        .cand_valid_i (cand_valid_o),
        .cand_key_i   (cand_key_o),
        .res_valid_i  (res_valid_i),
        .res_data_i   (res_data_i),
        .targets_i    (cfg_targets_i),
        .tgt_en_i     (cfg_tgt_en_i),
        .push_o       (any_match),
        .push_idx_o   (m_idx),
        .push_key_o   (m_key),
        .inflight_o   (inflight),
        .hit_mask_o   (hit_mask_o)
    );

    ks_fifo #(.W(IDX_W + KEY_W), .DEPTH(FIFO_D)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_ovf_i (accept),
        .push_i      (any_match),
        .data_i      ({m_idx, m_key}),
        .pop_i       (fifo_pop_i),
        .valid_o     (fifo_valid_o),
        .data_o      ({fifo_tgt_o, fifo_key_o}),
        .overflow_o  (overflow_o)
    );

    always_comb begin
        d = q;
        if (accept) begin
            d.active = 1'b1;
            d.done   = 1'b0;
        end else if (q.active && !cand_valid_o && !inflight) begin
            d.active = 1'b0;
            d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.active;
    assign done_o = q.done;
    assign hit_o  = |hit_mask_o;

    // R9: nothing is issued once the run is reported finished
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cand_valid_o);
    // R8: a stop request ends issuing at the next cycle
    a_r8_stop_ends_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !accept) |=> !cand_valid_o);
    // R2: issuing only happens inside an active run
    a_r2_issue_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid_o |-> busy_o);

endmodule

// File: tb/keysearch_ctrl_tb_top.sv
`timescale 1ns/1ps
module keysearch_ctrl_tb_top;

    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  cfg_start = '0;
    logic [5:0]   cfg_span = '0;
    logic [1:0]   cfg_mode = '0;
    logic         cfg_upper = 1'b0;
    logic         cfg_stop = 1'b0;
    logic [127:0] cfg_targets = '0;
    logic [3:0]   cfg_tgt_en = '0;
    logic         cand_valid;
    logic [31:0]  cand_key;
    logic         res_valid;
    logic [31:0]  res_data;
    logic [31:0]  pos;
    logic         busy, done, hit, overflow, fifo_valid;
    logic [3:0]   hit_mask;
    logic [1:0]   fifo_tgt;
    logic [31:0]  fifo_key;
    logic         fifo_pop = 1'b0;

    always #2.5 clk = ~clk;

    keysearch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cfg_start_i(cfg_start), .cfg_span_i(cfg_span), .cfg_mode_i(cfg_mode),
        .cfg_upper_i(cfg_upper), .cfg_stop_i(cfg_stop),
        .cfg_targets_i(cfg_targets), .cfg_tgt_en_i(cfg_tgt_en),
        .cand_valid_o(cand_valid), .cand_key_o(cand_key),
        .res_valid_i(res_valid), .res_data_i(res_data),
        .pos_o(pos), .busy_o(busy), .done_o(done), .hit_o(hit),
        .hit_mask_o(hit_mask), .overflow_o(overflow),
        .fifo_valid_o(fifo_valid), .fifo_tgt_o(fifo_tgt), .fifo_key_o(fifo_key),
        .fifo_pop_i(fifo_pop)
    );

    function automatic logic [31:0] fx(logic [31:0] k);
        return ((k ^ 32'hA5A55A5A) * 32'h0019660D) + 32'h3C6EF35F;
    endfunction

    // Model of the external fixed-latency cipher pipeline
    logic [LAT-1:0] pv = '0;
    logic [31:0]    pd [LAT];
    always @(posedge clk) begin
        pv    <= {pv[LAT-2:0], cand_valid};
        pd[0] <= fx(cand_key);
        for (int s = 1; s < LAT; s++) pd[s] <= pd[s-1];
    end
    assign res_valid = pv[LAT-1];
    assign res_data  = pd[LAT-1];

    int checks = 0;
    int errors = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Character tables built from the set definitions
    logic [7:0] tab [3][2][96];
    int         tlen [3][2];

    function automatic bit in_set(int m, int up, int c);
        bit ok;
        if (m == 1) ok = (c >= 32 && c <= 126);
        else ok = (c >= 48 && c <= 57) || (c >= 65 && c <= 90) || (c >= 97 && c <= 122);
        if (up && c >= 97 && c <= 122) ok = 0;
        return ok;
    endfunction

    initial begin
        for (int m = 1; m < 3; m++)
            for (int u = 0; u < 2; u++) begin
                tlen[m][u] = 0;
                for (int c = 0; c < 256; c++)
                    if (in_set(m, u, c)) begin
                        tab[m][u][tlen[m][u]] = 8'(c);
                        tlen[m][u]++;
                    end
            end
    end

    // Scoreboard of expected candidates
    logic [31:0] exp_q [$];
    logic [31:0] seq   [$];
    int n_iss, first_cyc, last_cyc, cyc;

    task automatic gen(logic [31:0] st, int span, int mode, int up, int limit);
        exp_q.delete();
        seq.delete();
        if (mode == 0) begin
            logic [31:0] mask, k;
            for (int b = 0; b < 32; b++) mask[b] = (b < span);
            k = st;
            while (1) begin
                exp_q.push_back(k); seq.push_back(k);
                if (limit != 0 && exp_q.size() == limit) break;
                if ((k & mask) == mask) break;
                k = (k & ~mask) | ((k + 1) & mask);
            end
        end else begin
            int dg [4];
            int r;
            r = tlen[mode][up];
            for (int i = 0; i < 4; i++) dg[i] = int'(st[8*i +: 8]);
            while (1) begin
                logic [31:0] key;
                bit all_max;
                int i;
                for (int j = 0; j < 4; j++) key[8*j +: 8] = tab[mode][up][dg[j]];
                exp_q.push_back(key); seq.push_back(key);
                if (limit != 0 && exp_q.size() == limit) break;
                all_max = 1;
                for (int j = 0; j < span && j < 4; j++) if (dg[j] != r - 1) all_max = 0;
                if (all_max) break;
                i = 0;
                while (i < span && i < 4) begin
                    if (dg[i] == r - 1) begin dg[i] = 0; i++; end
                    else begin dg[i]++; break; end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        if (rst_n && cand_valid) begin
            if (n_iss == 0) first_cyc = cyc;
            last_cyc = cyc;
            n_iss++;
            if (exp_q.size() == 0) chk("R2 extra candidate", {32'd0, cand_key}, 64'hFFFF_FFFF_FFFF_FFFF);
            else chk("R3/R4/R5/R6 candidate", {32'd0, cand_key}, {32'd0, exp_q.pop_front()});
        end
    end

    task automatic start_run(string req);
        n_iss = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(req, {63'd0, cand_valid}, 64'd1);
    endtask

    task automatic wait_done(string req);
        int n;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(req, {63'd0, done}, 64'd1);
        chk("R9 no issue when done", {63'd0, cand_valid}, 64'd0);
        chk("R2 all expected issued", 64'(exp_q.size()), 64'd0);
        chk("R2 no gap", 64'(last_cyc - first_cyc + 1), 64'(n_iss));
    endtask

    task automatic pop_expect(string req, logic [1:0] t, logic [31:0] k);
        chk(req, {63'd0, fifo_valid}, 64'd1);
        chk(req, {30'd0, fifo_tgt, fifo_key}, {30'd0, t, k});
        @(negedge clk) fifo_pop = 1'b1;
        @(negedge clk) fifo_pop = 1'b0;
    endtask

    initial begin
        cyc = 0; n_iss = 0; first_cyc = 0; last_cyc = 0;
        repeat (3) @(negedge clk);
        // R1 during and after reset
        chk("R1 cand_valid", {63'd0, cand_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 status", {58'd0, busy, done, hit, overflow, fifo_valid, cand_valid}, 64'd0);
        chk("R1 hit mask", {60'd0, hit_mask}, 64'd0);

        // Binary mode, two of three enabled targets hit, start ignored mid-run
        cfg_mode = 2'd0; cfg_span = 6'd4; cfg_start = 32'h1234_5670; cfg_stop = 0;
        cfg_targets = {fx(32'h1234_5675), fx(32'h1234_567C), fx(32'h9999_9999), fx(32'h1234_5673)};
        cfg_tgt_en = 4'b0111;
        gen(cfg_start, 4, 0, 0, 0);
        chk("R3 count", 64'(exp_q.size()), 64'd16);
        start_run("R2 first issue");
        repeat (3) @(negedge clk);
        start = 1'b1; @(negedge clk) start = 1'b0;   // R12 ignored while busy
        wait_done("R9 binary done");
        chk("R9 pos holds last", {32'd0, pos}, {32'd0, 32'h1234_567F});
        chk("R7 hit mask", {60'd0, hit_mask}, 64'b0101);
        pop_expect("R7 first match", 2'd0, 32'h1234_5673);
        pop_expect("R7 second match", 2'd2, 32'h1234_567C);
        chk("R7 no extra match", {63'd0, fifo_valid}, 64'd0);

        // Printable, upper-case folded, two digits across the letter gap
        cfg_mode = 2'd1; cfg_upper = 1; cfg_span = 6'd2;
        cfg_start = {8'd33, 8'd33, 8'd64, 8'd63};
        gen(cfg_start, 2, 1, 1, 0);
        chk("R6 printable folded count", 64'(exp_q.size()), 64'd282);
        cfg_targets = '0; cfg_targets[63:32] = fx(seq[100]); cfg_tgt_en = 4'b0010;
        start_run("R2 first issue printable");
        wait_done("R9 printable done");
        chk("R4 pos", {32'd0, pos}, {32'd0, 8'd33, 8'd33, 8'd68, 8'd68});
        pop_expect("R7 printable match", 2'd1, seq[100]);

        // Alphanumeric with stop on first match
        cfg_mode = 2'd2; cfg_upper = 0; cfg_span = 6'd1; cfg_start = 32'd0; cfg_stop = 1;
        gen(cfg_start, 1, 2, 0, 0);
        chk("R5 alnum count", 64'(exp_q.size()), 64'd62);
        chk("R5 alnum 'K'", {32'd0, seq[20]}, {32'd0, 32'h3030_304B});
        cfg_targets = '0; cfg_targets[127:96] = fx(seq[20]); cfg_tgt_en = 4'b1000;
        gen(cfg_start, 1, 2, 0, 21 + LAT);
        start_run("R2 first issue alnum");
        wait_done("R8 stop done");
        chk("R8 stop position", {32'd0, pos}, {32'd0, 32'd25});
        chk("R8 issued count", 64'(n_iss), 64'd25);
        pop_expect("R8 match in fifo", 2'd3, 32'h3030_304B);

        // Resume from the stop position
        cfg_stop = 0; cfg_start = pos;
        gen(cfg_start, 1, 2, 0, 0);
        chk("R10 resume count", 64'(exp_q.size()), 64'd37);
        start_run("R10 first issue resume");
        wait_done("R10 resume done");
        chk("R10 end pos", {32'd0, pos}, {32'd0, 32'd61});
        chk("R10 no match", {60'd0, hit_mask}, 64'd0);

        // Alphanumeric folded
        cfg_upper = 1; cfg_start = {8'd35, 8'd35, 8'd35, 8'd0}; cfg_tgt_en = '0;
        gen(cfg_start, 1, 2, 1, 0);
        chk("R6 alnum folded count", 64'(exp_q.size()), 64'd36);
        chk("R6 last is Z", {32'd0, seq[35]}, {32'd0, 32'h5A5A_5A5A});
        start_run("R6 first issue");
        wait_done("R6 done");

        // Multi-target priority and FIFO overflow
        cfg_mode = 2'd0; cfg_upper = 0; cfg_span = 6'd3; cfg_start = 32'd0;
        cfg_targets = {fx(32'd6), fx(32'd5), fx(32'd5), fx(32'd2)}; cfg_tgt_en = 4'b1111;
        gen(cfg_start, 3, 0, 0, 0);
        start_run("R2 first issue overflow a");
        wait_done("R7 multi done");
        chk("R7 all targets flagged", {60'd0, hit_mask}, 64'b1111);
        chk("R11 no overflow yet", {63'd0, overflow}, 64'd0);
        gen(cfg_start, 3, 0, 0, 0);
        start_run("R2 first issue overflow b");
        wait_done("R11 second done");
        chk("R11 overflow", {62'd0, overflow, hit}, 64'b11);
        pop_expect("R11 fifo 0", 2'd0, 32'd2);
        pop_expect("R7 lowest index", 2'd1, 32'd5);
        pop_expect("R11 fifo 2", 2'd3, 32'd6);
        pop_expect("R11 fifo 3", 2'd0, 32'd2);
        chk("R11 fifo empty", {63'd0, fifo_valid}, 64'd0);

        // Span zero gives one candidate
        cfg_span = 6'd0; cfg_start = 32'hDEAD_BEEF; cfg_tgt_en = '0;
        gen(cfg_start, 0, 0, 0, 0);
        start_run("R3 span zero issue");
        wait_done("R3 span zero done");
        chk("R3 single", 64'(n_iss), 64'd1);
        chk("R11 start clears overflow", {63'd0, overflow}, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule